// File: doc/BRIEF.md
# Internal Data Memory with Overlaid Special-Register Space

This block holds the 256-byte on-chip data memory of a small 8-bit controller together with the special-register file that shares the address range of its upper half. Each request carries an address, a read/write flag, write data, and a flag that says whether the instruction used direct or indirect addressing. Below 0x80 both addressing kinds reach the same memory bytes. From 0x80 upward the addressing kind alone picks the store. Indirect requests land in the upper 128 memory bytes. Direct requests land in the special registers.

The register file holds a handful of example registers: four port latches, an auxiliary control register, an accumulator and a second arithmetic register. The auxiliary register's bit 1 is exported as the external-memory select flag. A direct request to an upper address with no register behind it reads zero, changes nothing, and raises a one-cycle error flag. Writes commit on the rising clock edge. Read data is combinational from the current contents.

Top module: `idram_sfr_top`

## Requirements
- R1: For addresses 0x00 to 0x7F, direct and indirect requests reach the same memory byte: a byte written in one mode reads back in the other.
- R2: An indirect request to 0x80 to 0xFF reads and writes the upper memory byte at that address.
- R3: A direct request to 0x80 to 0xFF never reaches memory. A direct write to 0xA0 leaves memory byte 0xA0 unchanged.
- R4: An indirect write to any address leaves every special register unchanged. In particular, an indirect write to 0xA0 leaves the port-2 latch as it was.
- R5: A write takes effect at the rising clock edge. During the write cycle, `acc_rdata` still shows the old content of the addressed location, and it shows the new content after the edge.
- R6: A direct read of an upper address with no register behind it returns 0x00. A direct write there changes no register and no memory byte.
- R7: `sfr_err` is high in the cycle after a valid direct request to an unimplemented upper address, and it is low in the cycle after any other request or idle cycle.
- R8: The implemented registers sit at these addresses: port 0 at 0x80, port 1 at 0x90, port 2 at 0xA0, port 3 at 0xB0, auxiliary at 0x8E, accumulator at 0xE0, arithmetic B at 0xF0. A direct write to one of them reads back directly. `port_lat` bits [8k+7:8k] carry port k.
- R9: `extram` equals bit 1 of the auxiliary register (0x8E). It changes only on a direct write to 0x8E.
- R10: Reset sets all four port latches to 0xFF and sets the auxiliary, accumulator and B registers to 0x00. Memory contents after reset are undefined.
- R11: While `acc_valid` is low, nothing is written to memory or to the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_direct | input | 1 | 1 = direct addressing, 0 = indirect |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Combinational read data for the addressed location |
| sfr_err | output | 1 | One-cycle flag for a direct request to an unimplemented register |
| extram | output | 1 | External-memory select, bit 1 of the auxiliary register |
| port_lat | output | 32 | The four port latches, port k in bits [8k+7:8k] |

## Verification
The memory is first filled through indirect writes, so every byte has a known value. Random requests then mix both addressing kinds over the whole address range, with reads and writes across the lower half, the upper memory half, implemented registers and empty register addresses. Because the two stores are filled with different data, a request routed to the wrong store shows up as a read mismatch. Directed cases then target address 0xA0 from both sides, the pre-edge versus post-edge read value, error flags on back-to-back bad accesses, the auxiliary bit, idle cycles carrying write data, and the reset values.

// File: rtl/idram_pkg.sv
package idram_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned SFR_COUNT  = 7;
  localparam int unsigned PORT_COUNT = 4;
  localparam logic [7:0]  AUX_ADDR   = 8'h8E;
  localparam int unsigned EXTRAM_BIT = 1;
  localparam int unsigned AUX_INDEX  = 4;

  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_SFR  = 2'd1,
    TGT_MISS = 2'd2
  } target_e;

  // Register slots: 0..3 are the port latches, 4 is the auxiliary register.
  function automatic logic [7:0] sfr_addr_of(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h90;
      2:       return 8'hA0;
      3:       return 8'hB0;
      4:       return AUX_ADDR;
      5:       return 8'hE0;
      default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [7:0] sfr_reset_of(input int idx);
    return (idx < int'(PORT_COUNT)) ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/idram_ram.sv
module idram_ram #(
  parameter int unsigned ADDR_W = idram_pkg::ADDR_W,
  parameter int unsigned DATA_W = idram_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single port, write-first not required: read shows pre-edge contents.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/idram_sfr_file.sv
module idram_sfr_file #(
  parameter int unsigned ADDR_W = idram_pkg::ADDR_W,
  parameter int unsigned DATA_W = idram_pkg::DATA_W
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    we,
  input  logic [ADDR_W-1:0]                       addr,
  input  logic [DATA_W-1:0]                       wdata,
  output logic [DATA_W-1:0]                       rdata,
  output logic                                    hit,
  output logic                                    extram,
  output logic [idram_pkg::PORT_COUNT*DATA_W-1:0] port_lat
);

  import idram_pkg::*;

  logic [DATA_W-1:0]    regs_q [SFR_COUNT];
  logic [SFR_COUNT-1:0] match;

  for (genvar i = 0; i < int'(SFR_COUNT); i++) begin : g_reg
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(sfr_addr_of(i));
    localparam logic [DATA_W-1:0] SLOT_RST  = DATA_W'(sfr_reset_of(i));

    assign match[i] = (addr == SLOT_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= SLOT_RST;
      end else if (we && match[i]) begin
        regs_q[i] <= wdata;
      end
    end
  end

  for (genvar k = 0; k < int'(PORT_COUNT); k++) begin : g_port
    assign port_lat[k*DATA_W +: DATA_W] = regs_q[k];
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < int'(SFR_COUNT); j++) begin
      if (match[j]) begin
        rdata = rdata | regs_q[j];
      end
    end
  end

  assign hit    = |match;
  assign extram = regs_q[AUX_INDEX][EXTRAM_BIT];

endmodule

// File: rtl/idram_decode.sv
module idram_decode #(
  parameter int unsigned ADDR_W = idram_pkg::ADDR_W,
  parameter int unsigned DATA_W = idram_pkg::DATA_W
) (
  input  logic              valid,
  input  logic              we,
  input  logic              direct,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sfr_hit,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic              ram_we,
  output logic              sfr_we,
  output logic [DATA_W-1:0] rdata,
  output logic              miss
);

  import idram_pkg::*;

  target_e tgt;

  always_comb begin
    if (direct && addr[ADDR_W-1]) begin
      tgt = sfr_hit ? TGT_SFR : TGT_MISS;
    end else begin
      tgt = TGT_RAM;
    end
  end

  always_comb begin
    ram_we = 1'b0;
    sfr_we = 1'b0;
    miss   = 1'b0;
    rdata  = '0;
    unique case (tgt)
      TGT_RAM: begin
        ram_we = valid && we;
        rdata  = ram_rdata;
      end
      TGT_SFR: begin
        sfr_we = valid && we;
        rdata  = sfr_rdata;
      end
      default: begin
        miss = valid;
      end
    endcase
  end

endmodule

// File: rtl/idram_sfr_top.sv
module idram_sfr_top #(
  parameter int unsigned ADDR_W = idram_pkg::ADDR_W,
  parameter int unsigned DATA_W = idram_pkg::DATA_W
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    acc_valid,
  input  logic                                    acc_we,
  input  logic                                    acc_direct,
  input  logic [ADDR_W-1:0]                       acc_addr,
  input  logic [DATA_W-1:0]                       acc_wdata,
  output logic [DATA_W-1:0]                       acc_rdata,
  output logic                                    sfr_err,
  output logic                                    extram,
  output logic [idram_pkg::PORT_COUNT*DATA_W-1:0] port_lat
);

  logic              ram_we_w;
  logic              sfr_we_w;
  logic              sfr_hit_w;
  logic              miss_w;
  logic [DATA_W-1:0] ram_rdata_w;
  logic [DATA_W-1:0] sfr_rdata_w;

  idram_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we_w),
    .addr  (acc_addr),
    .wdata (acc_wdata),
    .rdata (ram_rdata_w)
  );

  idram_sfr_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sfr (
    .clk      (clk),
    .rst      (rst),
    .we       (sfr_we_w),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .rdata    (sfr_rdata_w),
    .hit      (sfr_hit_w),
    .extram   (extram),
    .port_lat (port_lat)
  );

  idram_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .valid     (acc_valid),
    .we        (acc_we),
    .direct    (acc_direct),
    .addr      (acc_addr),
    .sfr_hit   (sfr_hit_w),
    .ram_rdata (ram_rdata_w),
    .sfr_rdata (sfr_rdata_w),
    .ram_we    (ram_we_w),
    .sfr_we    (sfr_we_w),
    .rdata     (acc_rdata),
    .miss      (miss_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_err <= 1'b0;
    end else begin
      sfr_err <= miss_w;
    end
  end

endmodule

// File: rtl/idram_sfr_chk.sv
module idram_sfr_chk #(
  parameter int unsigned ADDR_W = idram_pkg::ADDR_W,
  parameter int unsigned DATA_W = idram_pkg::DATA_W
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic                                    acc_valid,
  input logic                                    acc_we,
  input logic                                    acc_direct,
  input logic [ADDR_W-1:0]                       acc_addr,
  input logic [DATA_W-1:0]                       acc_rdata,
  input logic                                    sfr_err,
  input logic                                    extram,
  input logic [idram_pkg::PORT_COUNT*DATA_W-1:0] port_lat,
  input logic                                    sfr_hit,
  input logic                                    ram_we,
  input logic                                    sfr_we
);

  logic bad_req;
  logic aux_wr;
  logic sfr_side_wr;

  assign bad_req     = acc_valid && acc_direct && acc_addr[ADDR_W-1] && !sfr_hit;
  assign aux_wr      = acc_valid && acc_we && acc_direct &&
                       (acc_addr == ADDR_W'(idram_pkg::AUX_ADDR));
  assign sfr_side_wr = acc_valid && acc_we && acc_direct && acc_addr[ADDR_W-1];

  p_miss_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    bad_req |-> (acc_rdata == '0));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> sfr_err);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !bad_req |=> !sfr_err);

  p_extram_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !aux_wr |=> $stable(extram));

  p_ports_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sfr_side_wr |=> $stable(port_lat));

  p_direct_upper_no_ram_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_direct && acc_addr[ADDR_W-1]) |-> !ram_we);

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!ram_we && !sfr_we));

  p_reset_values_r10: assert property (@(posedge clk)
    rst |=> (port_lat == '1 && !extram && !sfr_err));

endmodule

bind idram_sfr_top idram_sfr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_we     (acc_we),
  .acc_direct (acc_direct),
  .acc_addr   (acc_addr),
  .acc_rdata  (acc_rdata),
  .sfr_err    (sfr_err),
  .extram     (extram),
  .port_lat   (port_lat),
  .sfr_hit    (sfr_hit_w),
  .ram_we     (ram_we_w),
  .sfr_we     (sfr_we_w)
);

// File: tb/idram_sfr_top_tb_top.sv
`timescale 1ns/1ps
module idram_sfr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic        acc_direct = 1'b0;
  logic [7:0]  acc_addr = 8'h00;
  logic [7:0]  acc_wdata = 8'h00;
  logic [7:0]  acc_rdata;
  logic        sfr_err;
  logic        extram;
  logic [31:0] port_lat;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [256];
  logic       err_m;

  always #4 clk = ~clk;

  idram_sfr_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_we     (acc_we),
    .acc_direct (acc_direct),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .sfr_err    (sfr_err),
    .extram     (extram),
    .port_lat   (port_lat)
  );

  function automatic bit impl(input logic [7:0] a);
    return a == 8'h80 || a == 8'h90 || a == 8'hA0 || a == 8'hB0 ||
           a == 8'h8E || a == 8'hE0 || a == 8'hF0;
  endfunction

  function automatic logic [7:0] model_rd(input logic dir, input logic [7:0] a);
    if (dir && a[7]) return impl(a) ? sfr_m[a] : 8'h00;
    return ram_m[a];
  endfunction

  function automatic string region(input logic dir, input logic [7:0] a);
    if (!a[7]) return "R1";
    if (!dir)  return "R2";
    return impl(a) ? "R8" : "R6";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int i = 0; i < 256; i++) sfr_m[i] = 8'h00;
    sfr_m[8'h80] = 8'hFF; sfr_m[8'h90] = 8'hFF;
    sfr_m[8'hA0] = 8'hFF; sfr_m[8'hB0] = 8'hFF;
    err_m = 1'b0;
  endtask

  function automatic logic [31:0] model_ports();
    return {sfr_m[8'hB0], sfr_m[8'hA0], sfr_m[8'h90], sfr_m[8'h80]};
  endfunction

  // One request: driven after a falling edge, checked before and after the rising edge.
  task automatic op(input logic v, input logic we, input logic dir,
                    input logic [7:0] a, input logic [7:0] d, input bit chk_rd);
    @(negedge clk);
    acc_valid = v; acc_we = we; acc_direct = dir; acc_addr = a; acc_wdata = d;
    #1;
    if (chk_rd) check({region(dir, a), " read"}, {24'h0, acc_rdata}, {24'h0, model_rd(dir, a)});
    @(posedge clk);
    if (v && we) begin
      if (dir && a[7]) begin
        if (impl(a)) sfr_m[a] = d;
      end else begin
        ram_m[a] = d;
      end
    end
    err_m = v && dir && a[7] && !impl(a);
    #1;
    check("R7 err", {31'h0, sfr_err}, {31'h0, err_m});
    check("R9 extram", {31'h0, extram}, {31'h0, sfr_m[8'h8E][1]});
    check("R4 ports", port_lat, model_ports());
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C51));
    reset_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset values
    check("R10 ports", port_lat, 32'hFFFF_FFFF);
    check("R10 extram", {31'h0, extram}, 32'h0);
    check("R10 err", {31'h0, sfr_err}, 32'h0);
    acc_direct = 1'b1; acc_addr = 8'hE0; #1;
    check("R10 acc", {24'h0, acc_rdata}, 32'h0);

    // Fill memory through indirect writes.
    for (int i = 0; i < 256; i++) op(1'b1, 1'b1, 1'b0, 8'(i), 8'(i * 7 + 3), 1'b0);

    // R1: write direct low, read indirect (and the reverse).
    op(1'b1, 1'b1, 1'b1, 8'h35, 8'hC3, 1'b0);
    op(1'b1, 1'b0, 1'b0, 8'h35, 8'h00, 1'b1);
    op(1'b1, 1'b1, 1'b0, 8'h7F, 8'h5A, 1'b0);
    op(1'b1, 1'b0, 1'b1, 8'h7F, 8'h00, 1'b1);

    // R3: direct write to port 2 leaves memory byte 0xA0 alone.
    op(1'b1, 1'b1, 1'b1, 8'hA0, 8'h12, 1'b0);
    op(1'b1, 1'b0, 1'b0, 8'hA0, 8'h00, 1'b1);
    check("R3 ram A0", {24'h0, acc_rdata}, {24'h0, ram_m[8'hA0]});
    // R4: indirect write to 0xA0 leaves port 2 alone.
    op(1'b1, 1'b1, 1'b0, 8'hA0, 8'hEE, 1'b0);
    check("R4 p2", {24'h0, port_lat[23:16]}, 32'h12);
    op(1'b1, 1'b0, 1'b1, 8'hA0, 8'h00, 1'b1);

    // R5: old value before the edge, new value after it.
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; acc_direct = 1'b0; acc_addr = 8'hC4; acc_wdata = 8'h99;
    #1;
    check("R5 pre-edge", {24'h0, acc_rdata}, {24'h0, ram_m[8'hC4]});
    @(posedge clk); ram_m[8'hC4] = 8'h99; #1;
    check("R5 post-edge", {24'h0, acc_rdata}, 32'h99);

    // R6/R7: unimplemented register, back to back, then a good access.
    op(1'b1, 1'b1, 1'b1, 8'h85, 8'h77, 1'b1);
    op(1'b1, 1'b0, 1'b1, 8'h85, 8'h00, 1'b1);
    op(1'b1, 1'b0, 1'b0, 8'h85, 8'h00, 1'b1);
    check("R6 ram 85", {24'h0, acc_rdata}, {24'h0, ram_m[8'h85]});
    op(1'b1, 1'b0, 1'b1, 8'h90, 8'h00, 1'b1);
    op(1'b0, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0);

    // R9: auxiliary bit 1 drives extram.
    op(1'b1, 1'b1, 1'b1, 8'h8E, 8'h02, 1'b0);
    check("R9 set", {31'h0, extram}, 32'h1);
    op(1'b1, 1'b1, 1'b1, 8'h8E, 8'hFD, 1'b0);
    check("R9 clear", {31'h0, extram}, 32'h0);

    // R11: idle cycles with write data do nothing.
    op(1'b0, 1'b1, 1'b1, 8'hB0, 8'h00, 1'b0);
    op(1'b0, 1'b1, 1'b0, 8'h10, 8'hAB, 1'b0);
    op(1'b1, 1'b0, 1'b0, 8'h10, 8'h00, 1'b1);
    check("R11 idle", {24'h0, acc_rdata}, {24'h0, ram_m[8'h10]});

    // Random mix, R1 R2 R6 R8 tagged by region.
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      a = (pick == 3'd0) ? 8'(8'h80 + 8'($urandom_range(0, 6)) * 8'h10) :
          (pick == 3'd1) ? 8'h8E : 8'($urandom);
      op(1'($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), a, 8'($urandom), 1'b1);
    end

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule